// File: doc/BRIEF.md
# Front-Side Bus Cycle Terminator

This block ends the bus cycles of an asynchronous processor bus. The bus has an active-low address strobe and two active-low acknowledge lines. One acknowledge line is for ordinary memory-style targets. The other is for slow, peripheral-style targets. The strobe is asserted after a rising clock edge and released after a falling edge. The processor's output delay can be as long as half a clock period, so sampling the strobe on only one edge would risk metastability. To avoid this, the block builds a bus-active flag. The flag is the OR of the live strobe and a copy of the strobe captured on the falling edge. This flag is settled at every rising edge, and the acknowledge logic samples it there.

The address is decoded into one of three targets: a ROM window, a peripheral range, or general memory. The ROM window also drives an active-low chip select. Each target has its own ready input. Only the ready of the selected target can end the cycle. Once that ready is seen, the block drives the acknowledge line that belongs to the target. It holds that line until the bus-active flag drops, so one acknowledge never covers two cycles.

The block has no streaming data interface, so there is no valid/ready back-pressure. All pins are plain control levels. The reset is synchronous and active high.

Top module: `fsb_cycle_term`

## Requirements
- R1: While and right after reset, `bus_act` is 0 and `dtack_n`, `vpa_n` and `romcs_n` are all 1.
- R2: `bus_act` rises as soon as `as_n` goes low, without waiting for any clock edge.
- R3: After `as_n` returns high, `bus_act` stays 1 until the next falling clock edge and then reads 0.
- R4: `romcs_n` is 0 exactly when `bus_act` is 1 and the address lies in 0x400000..0x4FFFFF. The bounds are inclusive: 0x3FFFFF and 0x500000 leave it high.
- R5: An acknowledge is raised at the first rising edge where `bus_act` is 1 and the ready input of the selected target is 1. Ready inputs of targets that are not selected have no effect.
- R6: Addresses 0xE00000..0xFFFFFF select the peripheral target and are acknowledged on `vpa_n`. All other addresses are acknowledged on `dtack_n`. The two lines are never low together.
- R7: `vpa_n` goes high as soon as `as_n` goes high. `dtack_n` ignores the live strobe and stays low while `bus_act` is 1.
- R8: Whenever `bus_act` is 0, both `dtack_n` and `vpa_n` are 1.
- R9: Once raised, an acknowledge stays asserted for the rest of the cycle even if ready falls. The next cycle starts unacknowledged and needs its own ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| as_n | input | 1 | Address strobe from the processor, active low, asynchronous |
| addr | input | 24 | Bus address |
| rdy_ram | input | 1 | Ready from the general memory target |
| rdy_rom | input | 1 | Ready from the ROM target |
| rdy_per | input | 1 | Ready from the peripheral target |
| bus_act | output | 1 | Bus-active flag, valid at every rising edge |
| romcs_n | output | 1 | ROM chip select, active low |
| dtack_n | output | 1 | Memory-style acknowledge, active low |
| vpa_n | output | 1 | Peripheral-style acknowledge, active low |

## Verification
The bench probes `bus_act` in the window between the strobe's release and the next falling edge. A design that dropped the registered term would let the acknowledge fall early there. A design that dropped the live term would miss the first half-cycle of the strobe.

It also releases the strobe during a peripheral cycle and checks that `vpa_n` rises at once while `dtack_n` would have stayed low. A ready pulse from a target that is not selected must not end a ROM cycle. The ROM window bounds are probed one address on either side.

Ready is dropped after the acknowledge to show that the acknowledge is latched. Back-to-back cycles with ready held high show that each cycle waits for its own rising edge and does not inherit the previous acknowledge.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
  typedef enum logic [1:0] {
    TGT_RAM = 2'd0,
    TGT_ROM = 2'd1,
    TGT_PER = 2'd2
  } tgt_e;

  localparam int NUM_TGT = 3;
endpackage

// File: rtl/fsb_strobe_track.sv
// Captures the strobe on the falling edge and ORs it with the live strobe,
// giving a flag that is settled by the following rising edge.
module fsb_strobe_track (
  input  logic clk,
  input  logic rst,
  input  logic as_n,
  output logic bus_act
);
  logic as_fall_q;

  always_ff @(negedge clk) begin
    if (rst) as_fall_q <= 1'b0;
    else     as_fall_q <= ~as_n;
  end

  assign bus_act = ~as_n | as_fall_q;
endmodule

// File: rtl/fsb_addr_decode.sv
// Maps the address to a target (ROM has priority over the peripheral range)
// and picks that target's ready out of the ready vector.
module fsb_addr_decode
  import fsb_pkg::*;
#(
  parameter int          AW       = 24,
  parameter logic [AW-1:0] ROM_BASE = 24'h400000,
  parameter logic [AW-1:0] ROM_MASK = 24'hF00000,
  parameter logic [AW-1:0] PER_BASE = 24'hE00000,
  parameter logic [AW-1:0] PER_MASK = 24'hE00000
) (
  input  logic [AW-1:0]      addr,
  input  logic [NUM_TGT-1:0] rdy_vec,
  output tgt_e               tgt,
  output logic               rdy_sel
);
  logic hit_rom, hit_per;

  assign hit_rom = (addr & ROM_MASK) == ROM_BASE;
  assign hit_per = (addr & PER_MASK) == PER_BASE;

  always_comb begin
    if (hit_rom)      tgt = TGT_ROM;
    else if (hit_per) tgt = TGT_PER;
    else              tgt = TGT_RAM;
  end

  logic [NUM_TGT-1:0] rdy_gated;
  for (genvar i = 0; i < NUM_TGT; i++) begin : g_rdy
    assign rdy_gated[i] = rdy_vec[i] & (tgt == tgt_e'(i));
  end

  assign rdy_sel = |rdy_gated;
endmodule

// File: rtl/fsb_ack_gen.sv
// Latches which acknowledge line to drive at the first ready rising edge
// and holds it until bus-active is seen low at a rising edge.
module fsb_ack_gen
  import fsb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic as_n,
  input  logic bus_act,
  input  tgt_e tgt,
  input  logic rdy_sel,
  output logic dtack_n,
  output logic vpa_n
);
  logic ack_dtk_q, ack_vpa_q;

  always_ff @(posedge clk) begin
    if (rst || !bus_act) begin
      ack_dtk_q <= 1'b0;
      ack_vpa_q <= 1'b0;
    end else if (!ack_dtk_q && !ack_vpa_q && rdy_sel) begin
      ack_vpa_q <= (tgt == TGT_PER);
      ack_dtk_q <= (tgt != TGT_PER);
    end
  end

  assign dtack_n = ~(ack_dtk_q & bus_act);
  assign vpa_n   = ~(ack_vpa_q & bus_act & ~as_n);
endmodule

// File: rtl/fsb_cycle_term.sv
module fsb_cycle_term
  import fsb_pkg::*;
#(
  parameter int            AW       = 24,
  parameter logic [AW-1:0] ROM_BASE = 24'h400000,
  parameter logic [AW-1:0] ROM_MASK = 24'hF00000,
  parameter logic [AW-1:0] PER_BASE = 24'hE00000,
  parameter logic [AW-1:0] PER_MASK = 24'hE00000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          as_n,
  input  logic [AW-1:0] addr,
  input  logic          rdy_ram,
  input  logic          rdy_rom,
  input  logic          rdy_per,
  output logic          bus_act,
  output logic          romcs_n,
  output logic          dtack_n,
  output logic          vpa_n
);
  tgt_e               tgt;
  logic               rdy_sel;
  logic [NUM_TGT-1:0] rdy_vec;

  always_comb begin
    rdy_vec          = '0;
    rdy_vec[TGT_RAM] = rdy_ram;
    rdy_vec[TGT_ROM] = rdy_rom;
    rdy_vec[TGT_PER] = rdy_per;
  end

  fsb_strobe_track u_strobe (
    .clk     (clk),
    .rst     (rst),
    .as_n    (as_n),
    .bus_act (bus_act)
  );

  fsb_addr_decode #(
    .AW       (AW),
    .ROM_BASE (ROM_BASE),
    .ROM_MASK (ROM_MASK),
    .PER_BASE (PER_BASE),
    .PER_MASK (PER_MASK)
  ) u_dec (
    .addr    (addr),
    .rdy_vec (rdy_vec),
    .tgt     (tgt),
    .rdy_sel (rdy_sel)
  );

  fsb_ack_gen u_ack (
    .clk     (clk),
    .rst     (rst),
    .as_n    (as_n),
    .bus_act (bus_act),
    .tgt     (tgt),
    .rdy_sel (rdy_sel),
    .dtack_n (dtack_n),
    .vpa_n   (vpa_n)
  );

  assign romcs_n = ~(bus_act & (tgt == TGT_ROM));
endmodule

// File: rtl/fsb_cycle_term_chk.sv
module fsb_cycle_term_chk (
  input logic clk,
  input logic rst,
  input logic as_n,
  input logic bus_act,
  input logic romcs_n,
  input logic dtack_n,
  input logic vpa_n
);
  // R6
  one_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !(!dtack_n && !vpa_n));

  // R8
  idle_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_act |-> (dtack_n && vpa_n));

  // R7
  vpa_live_chk: assert property (@(posedge clk) disable iff (rst)
    as_n |-> vpa_n);

  // R4
  romcs_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_act |-> romcs_n);

  // R2
  strobe_active_chk: assert property (@(posedge clk) disable iff (rst)
    !as_n |-> bus_act);

  // R9
  ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!dtack_n ##1 bus_act) |-> !dtack_n);
endmodule

bind fsb_cycle_term fsb_cycle_term_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .as_n    (as_n),
  .bus_act (bus_act),
  .romcs_n (romcs_n),
  .dtack_n (dtack_n),
  .vpa_n   (vpa_n)
);

// File: tb/sim_fsb_cycle_term.sv
module sim_fsb_cycle_term;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        as_n = 1'b1;
  logic [23:0] addr = '0;
  logic        rdy_ram = 1'b0, rdy_rom = 1'b0, rdy_per = 1'b0;
  logic        bus_act, romcs_n, dtack_n, vpa_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  fsb_cycle_term u0 (
    .clk(clk), .rst(rst), .as_n(as_n), .addr(addr),
    .rdy_ram(rdy_ram), .rdy_rom(rdy_rom), .rdy_per(rdy_per),
    .bus_act(bus_act), .romcs_n(romcs_n), .dtack_n(dtack_n), .vpa_n(vpa_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic at_rise(); @(posedge clk); #2; endtask
  task automatic at_fall(); @(negedge clk); #2; endtask

  task automatic begin_cyc(input logic [23:0] a);
    at_rise();
    addr = a;
    as_n = 1'b0;
    #1;
  endtask

  // Release after a falling edge; then wait for bus-active to drop and ack to clear.
  task automatic finish_cyc();
    at_fall();
    as_n = 1'b1;
    #1;
    chk("R3 held after release", bus_act, 1'b1);
    at_fall();
    chk("R3 drops at falling edge", bus_act, 1'b0);
    chk("R8 dtack_n idle", dtack_n, 1'b1);
    chk("R8 vpa_n idle", vpa_n, 1'b1);
    at_rise();
  endtask

  task automatic t_reset();
    chk("R1 bus_act", bus_act, 1'b0);
    chk("R1 dtack_n", dtack_n, 1'b1);
    chk("R1 vpa_n", vpa_n, 1'b1);
    chk("R1 romcs_n", romcs_n, 1'b1);
  endtask

  task automatic t_ram_cycle();
    rdy_ram = 1'b1;
    begin_cyc(24'h001000);
    chk("R2 bus_act immediate", bus_act, 1'b1);
    chk("R4 romcs_n off outside window", romcs_n, 1'b1);
    chk("R5 no ack before edge", dtack_n, 1'b1);
    at_rise();
    chk("R5 dtack_n asserted", dtack_n, 1'b0);
    chk("R6 vpa_n unused for memory", vpa_n, 1'b1);
    at_fall();
    as_n = 1'b1;
    #1;
    chk("R7 dtack_n ignores live strobe", dtack_n, 1'b0);
    chk("R3 held after release", bus_act, 1'b1);
    at_fall();
    chk("R3 drops at falling edge", bus_act, 1'b0);
    chk("R8 dtack_n idle", dtack_n, 1'b1);
    at_rise();
    rdy_ram = 1'b0;
  endtask

  task automatic t_per_cycle();
    rdy_per = 1'b1;
    begin_cyc(24'hE80000);
    at_rise();
    chk("R6 vpa_n asserted", vpa_n, 1'b0);
    chk("R6 dtack_n unused for peripheral", dtack_n, 1'b1);
    at_fall();
    as_n = 1'b1;
    #1;
    chk("R7 vpa_n follows live strobe", vpa_n, 1'b1);
    chk("R7 bus_act still high", bus_act, 1'b1);
    at_fall();
    chk("R8 vpa_n idle", vpa_n, 1'b1);
    at_rise();
    rdy_per = 1'b0;
  endtask

  task automatic t_rom_wait();
    rdy_ram = 1'b1;
    rdy_per = 1'b1;
    begin_cyc(24'h400000);
    chk("R4 romcs_n active", romcs_n, 1'b0);
    for (int i = 0; i < 3; i++) begin
      at_rise();
      chk("R5 foreign ready ignored", dtack_n, 1'b1);
      chk("R5 foreign ready ignored vpa", vpa_n, 1'b1);
    end
    rdy_rom = 1'b1;
    at_rise();
    chk("R5 rom ready ends cycle", dtack_n, 1'b0);
    rdy_rom = 1'b0;
    at_rise();
    chk("R9 ack held after ready drops", dtack_n, 1'b0);
    finish_cyc();
    chk("R4 romcs_n off after cycle", romcs_n, 1'b1);
    rdy_ram = 1'b0;
    rdy_per = 1'b0;
  endtask

  task automatic t_bounds();
    begin_cyc(24'h3FFFFF);
    chk("R4 0x3FFFFF outside", romcs_n, 1'b1);
    addr = 24'h4FFFFF;
    #1;
    chk("R4 0x4FFFFF inside", romcs_n, 1'b0);
    addr = 24'h500000;
    #1;
    chk("R4 0x500000 outside", romcs_n, 1'b1);
    finish_cyc();
    addr = 24'h400000;
    #1;
    chk("R4 idle with rom address", romcs_n, 1'b1);
  endtask

  task automatic t_back2back();
    rdy_ram = 1'b1;
    begin_cyc(24'h010000);
    at_rise();
    chk("R9 first cycle acked", dtack_n, 1'b0);
    finish_cyc();
    begin_cyc(24'h020000);
    chk("R9 fresh cycle unacked", dtack_n, 1'b1);
    at_rise();
    chk("R9 second cycle acked", dtack_n, 1'b0);
    finish_cyc();
    rdy_ram = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    rst = 1'b0;
    at_rise();
    t_reset();
    t_ram_cycle();
    t_per_cycle();
    t_rom_wait();
    t_bounds();
    t_back2back();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule